// File: doc/BRIEF.md
# Boost Converter Power Stage Emulator

This block reproduces, in real time, the electrical behaviour of an ideal boost power stage so that a digital controller can be validated against it in hardware. It holds two state registers, inductor current and capacitor voltage, and advances both by one explicit Euler step of 20 ns each time the step enable is high. The inputs are the supply voltage, the load resistance in ohms and the power switch command. The output is the capacitor voltage, which is the converter output seen by the controller under test.

The load-dependent decay factor of the capacitor voltage is derived inside the block from the resistance input. A bit-serial divider computes it and restarts on every change of the resistance. Until a fresh quotient arrives, the previous factor stays in use. The diode is ideal, so the inductor current never goes below zero. With the switch toggled at 1 MHz, one switching period spans exactly 50 steps.

Top module: `bep_plant`

## Requirements
- R1: An asynchronous active-low reset clears both state registers immediately, so `vout_q` reads 0, and the block then recomputes the decay factor for the present load.
- R2: While `step_en` is low, both state registers hold, whatever `vin_q`, `sw_closed` or `load_ohm` do.
- R3: With `sw_closed` = 1 (switch conducting), a step applies iL ← iL + (dt/L)·vin and vC ← k·vC. The capacitor receives no inductor current.
- R4: With `sw_closed` = 0 (diode conducting), a step applies iL ← iL + (dt/L)·(vin − vC) and vC ← k·vC + (dt/C)·iL.
- R5: The new inductor current is saturated at a lower bound of zero.
- R6: A step uses the `vin_q` and `sw_closed` values present at the same clock edge, and the iL and vC values from before that edge.
- R7: The decay factor is k = 1 − dt/(R·C), with R = `load_ohm` as an unsigned integer in ohms, dt = 20 ns, L = 25 µH and C = 300 nF. It is computed by a sequential divider that restarts whenever `load_ohm` changes.
- R8: A load of 0 Ω saturates the quotient to all ones, which makes k = 0. A step with the switch closed then leaves `vout_q` at exactly 0.
- R9: While a division is in progress, steps keep using the previous decay factor.
- R10: `vin_q` and `vout_q` are unsigned fixed point with 8 integer bits and 24 fraction bits, in volts. Internal state is 38-bit unsigned with 30 fraction bits.
- R11: Over switching periods of 50 steps at 24 % on-time, with vin in 2.3–2.7 V and R in 280–430 Ω, `vout_q` tracks a double-precision evaluation of R3–R5 within 1 % (plus 1 mV).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance the state by one Euler step |
| vin_q | input | 32 | Supply voltage, unsigned 8.24 volts |
| load_ohm | input | 16 | Load resistance, unsigned integer ohms |
| sw_closed | input | 1 | 1 = power switch conducting |
| vout_q | output | 32 | Capacitor voltage, unsigned 8.24 volts |

## Verification
The hardest window to reach from the ports is the stretch in which the divider is still busy: during it, steps must use the old decay factor. Two nearby factors in the normal load range differ far below any measurable tolerance, so the stimulus first charges the capacitor, then switches the load to 0 Ω in the same cycle as a closed-switch step. That step must leave the output almost unchanged. After the divider settles, a second closed-switch step must drive the output to exactly zero. Reaching the zero-current clamp needs a charged capacitor, a supply below it and a long run with the switch open; the bench reaches it after a full boost run.

// File: rtl/bep_pkg.sv
`timescale 1ns/1ps
package bep_pkg;
  // state word: unsigned, 8 integer bits
  localparam int unsigned ST_W      = 38;
  localparam int unsigned ST_FRAC   = 30;
  // external voltage word
  localparam int unsigned PORT_W    = 32;
  localparam int unsigned PORT_FRAC = 24;
  // load resistance in ohms
  localparam int unsigned LOAD_W    = 16;

  // physical constants in integer units (ps, pH, pF)
  localparam longint unsigned DT_PS = 20_000;
  localparam longint unsigned L_PH  = 25_000_000;
  localparam longint unsigned C_PF  = 300_000;

  // dt/L and dt/C scaled by 2^ST_FRAC, rounded
  localparam longint unsigned KL_RAW = ((DT_PS << ST_FRAC) + L_PH / 2) / L_PH;
  localparam longint unsigned KC_RAW = ((DT_PS << ST_FRAC) + C_PF / 2) / C_PF;
endpackage

// File: rtl/bep_div.sv
`timescale 1ns/1ps
module bep_div #(
  parameter int unsigned NW = 38,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int unsigned CW = $clog2(NW + 1);

  logic [DW-1:0] rem_q, rem_d;
  logic [NW-1:0] sh_q, sh_d;
  logic [DW-1:0] den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;

  logic [DW:0]   trial;
  logic          fits;
  logic [DW-1:0] diff;

  assign trial = {rem_q, sh_q[NW-1]};
  assign fits  = (trial >= {1'b0, den_q});
  assign diff  = trial[DW-1:0] - den_q;

  always_comb begin
    rem_d  = rem_q;
    sh_d   = sh_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start && !busy_q) begin
      den_d = den;
      rem_d = '0;
      cnt_d = CW'(NW);
      if (den == '0) begin
        // zero divisor: saturated quotient, ready next cycle
        sh_d   = '1;
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        sh_d   = num;
        busy_d = 1'b1;
      end
    end else if (busy_q) begin
      rem_d = fits ? diff : trial[DW-1:0];
      sh_d  = {sh_q[NW-2:0], fits};
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      sh_q   <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      sh_q   <= sh_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = sh_q;

  // R7
  div_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q && den != '0) |=> busy_q);

  // R8
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q && den == '0) |=> (done_q && quo == '1));
endmodule

// File: rtl/bep_coef.sv
`timescale 1ns/1ps
module bep_coef #(
  parameter int unsigned     SW  = 38,
  parameter int unsigned     FW  = 30,
  parameter int unsigned     LW  = 16,
  parameter logic [SW-1:0]   NUM = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] load,
  output logic [SW-1:0] decay
);
  localparam logic [SW-1:0] ONE = SW'(1) << FW;

  logic          div_busy, div_done, div_start;
  logic [SW-1:0] div_quo;

  logic [LW-1:0] seen_q, seen_d;
  logic          fresh_q, fresh_d;
  logic [SW-1:0] decay_q, decay_d;

  assign div_start = !div_busy && (fresh_q || load != seen_q);

  bep_div #(.NW(SW), .DW(LW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (NUM),
    .den   (load),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo)
  );

  always_comb begin
    seen_d  = seen_q;
    fresh_d = fresh_q;
    decay_d = decay_q;
    if (div_start) begin
      seen_d  = load;
      fresh_d = 1'b0;
    end
    if (div_done) begin
      decay_d = (div_quo >= ONE) ? '0 : (ONE - div_quo);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '0;
      fresh_q <= 1'b1;
      decay_q <= ONE;
    end else begin
      seen_q  <= seen_d;
      fresh_q <= fresh_d;
      decay_q <= decay_d;
    end
  end

  assign decay = decay_q;

  // R9
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_done |=> $stable(decay_q));

  // R8
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_done && seen_q == '0) |=> (decay_q == '0));
endmodule

// File: rtl/bep_integ.sv
`timescale 1ns/1ps
module bep_integ #(
  parameter int unsigned   SW  = 38,
  parameter int unsigned   FW  = 30,
  parameter int unsigned   PW  = 32,
  parameter int unsigned   PF  = 24,
  parameter logic [SW-1:0] K_L = '0,
  parameter logic [SW-1:0] K_C = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          sw_closed,
  input  logic [PW-1:0] vin,
  input  logic [SW-1:0] decay,
  output logic [PW-1:0] vout
);
  localparam int unsigned SH = FW - PF;

  function automatic logic [SW-1:0] qmul(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [2*SW-1:0] p;
    p = {{SW{1'b0}}, a} * {{SW{1'b0}}, b};
    p = p >> FW;
    return (|p[2*SW-1:SW]) ? '1 : p[SW-1:0];
  endfunction

  logic [SW-1:0] vin_s;
  logic [SW-1:0] il_q, il_d, vc_q, vc_d;
  logic [SW-1:0] t_vin, t_vcl, t_dec, t_ilc;
  logic [SW+1:0] il_sum;
  logic [SW:0]   vc_sum;

  // align the port word to the state word
  generate
    if (SW == PW + SH) begin : g_align_exact
      assign vin_s = {vin, {SH{1'b0}}};
      assign vout  = vc_q[SW-1 -: PW];
    end else begin : g_align_ext
      assign vin_s = SW'({vin, {SH{1'b0}}});
      assign vout  = vc_q[PW+SH-1 -: PW];
    end
  endgenerate

  always_comb begin
    t_vin = qmul(K_L, vin_s);
    t_vcl = qmul(K_L, vc_q);
    t_dec = qmul(decay, vc_q);
    t_ilc = qmul(K_C, il_q);

    il_sum = {2'b00, il_q} + {2'b00, t_vin};
    if (!sw_closed) il_sum = il_sum - {2'b00, t_vcl};
    if (il_sum[SW+1])   il_d = '0;
    else if (il_sum[SW]) il_d = '1;
    else                 il_d = il_sum[SW-1:0];

    vc_sum = {1'b0, t_dec};
    if (!sw_closed) vc_sum = vc_sum + {1'b0, t_ilc};
    vc_d = vc_sum[SW] ? '1 : vc_sum[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      il_q <= '0;
      vc_q <= '0;
    end else if (step_en) begin
      il_q <= il_d;
      vc_q <= vc_d;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(vc_q) && $stable(il_q)));

  // R3
  closed_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sw_closed) |=> (il_q >= $past(il_q)));

  // R4
  open_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !sw_closed && il_q == '0) |=> (vc_q <= $past(vc_q)));
endmodule

// File: rtl/bep_plant.sv
`timescale 1ns/1ps
module bep_plant #(
  parameter int unsigned SW = bep_pkg::ST_W,
  parameter int unsigned FW = bep_pkg::ST_FRAC,
  parameter int unsigned PW = bep_pkg::PORT_W,
  parameter int unsigned PF = bep_pkg::PORT_FRAC,
  parameter int unsigned LW = bep_pkg::LOAD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [PW-1:0] vin_q,
  input  logic [LW-1:0] load_ohm,
  input  logic          sw_closed,
  output logic [PW-1:0] vout_q
);
  localparam logic [SW-1:0] K_L = SW'(bep_pkg::KL_RAW);
  localparam logic [SW-1:0] K_C = SW'(bep_pkg::KC_RAW);

  logic [SW-1:0] decay;

  bep_coef #(.SW(SW), .FW(FW), .LW(LW), .NUM(K_C)) u_coef (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_ohm),
    .decay (decay)
  );

  bep_integ #(.SW(SW), .FW(FW), .PW(PW), .PF(PF), .K_L(K_L), .K_C(K_C)) u_integ (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .sw_closed (sw_closed),
    .vin       (vin_q),
    .decay     (decay),
    .vout      (vout_q)
  );
endmodule

// File: tb/bep_plant_tb.sv
`timescale 1ns/1ps
module bep_plant_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic [31:0] vin_q;
  logic [15:0] load_ohm;
  logic        sw_closed;
  logic [31:0] vout_q;

  int checks = 0;
  int fails  = 0;

  real ref_il, ref_vc, ref_k;
  real KLR   = 20.0e-9 / 25.0e-6;
  real KCR   = 20.0e-9 / 300.0e-9;
  real SCALE = 16777216.0;

  always #5 clk = ~clk;

  bep_plant u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .vin_q(vin_q),
    .load_ohm(load_ohm), .sw_closed(sw_closed), .vout_q(vout_q)
  );

  function automatic real vo();
    return real'(vout_q) / SCALE;
  endfunction

  task automatic chk_close(input string tag, input real act, input real exp);
    real tol;
    tol = 0.01 * (exp < 0.0 ? -exp : exp) + 1.0e-3;
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      fails++;
      $display("FAIL %s actual=%f expected=%f", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    step_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_load(input int r);
    load_ohm = 16'(r);
    idle(60);
    ref_k = (r == 0) ? 0.0 : 1.0 - KCR / real'(r);
  endtask

  task automatic ref_clear();
    ref_il = 0.0;
    ref_vc = 0.0;
    ref_k  = 1.0;
  endtask

  // one Euler step: drive at a falling edge, compare at the next one
  task automatic step(input string tag, input real v, input bit sw);
    real vr, il_n, vc_n;
    vin_q     = 32'($rtoi(v * SCALE));
    sw_closed = sw;
    step_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vr   = real'(vin_q) / SCALE;
    il_n = ref_il + KLR * vr - (sw ? 0.0 : KLR * ref_vc);
    if (il_n < 0.0) il_n = 0.0;
    vc_n = ref_k * ref_vc + (sw ? 0.0 : KCR * ref_il);
    ref_il = il_n;
    ref_vc = vc_n;
    chk_close(tag, vo(), ref_vc);
  endtask

  task automatic pwm(input string tag, input int periods, input real v);
    for (int p = 0; p < periods; p++)
      for (int s = 0; s < 50; s++)
        step(tag, v, s < 12);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step_en = 1'b0; vin_q = '0; sw_closed = 1'b0; load_ohm = 16'd330;
    repeat (3) @(negedge clk);
    chk_eq("R1", vout_q, 32'h0);
    rst_n = 1'b1;
    ref_clear();
    set_load(330);
    chk_eq("R1", vout_q, 32'h0);
  endtask

  task automatic t_boost();
    pwm("R11/R3/R4", 40, 2.5);
  endtask

  task automatic t_hold();
    logic [31:0] held;
    step_en = 1'b0;
    @(negedge clk);
    held = vout_q;
    for (int i = 0; i < 20; i++) begin
      vin_q     = 32'h0280_0000 + 32'(i * 4099);
      sw_closed = i[0];
      @(negedge clk);
    end
    chk_eq("R2", vout_q, held);
    step("R2", 2.5, 1'b0);
  endtask

  task automatic t_vin();
    pwm("R10/R6", 10, 2.3);
    pwm("R10/R6", 10, 2.7);
  endtask

  task automatic t_load();
    set_load(430);
    pwm("R7", 10, 2.5);
    set_load(280);
    pwm("R7", 10, 2.5);
    set_load(330);
  endtask

  task automatic t_clamp();
    pwm("R5", 10, 2.5);
    for (int i = 0; i < 300; i++) step("R5", 2.3, 1'b0);
  endtask

  task automatic t_div_zero();
    pwm("R11", 5, 2.5);
    load_ohm = 16'd0;
    step("R9", 2.5, 1'b1);       // divider just started: old factor applies
    set_load(0);
    step("R8", 2.5, 1'b1);
    chk_eq("R8", vout_q, 32'h0);
    set_load(330);
    pwm("R11", 5, 2.5);
  endtask

  task automatic t_async();
    pwm("R1", 2, 2.5);
    step_en = 1'b0;
    #2 rst_n = 1'b0;
    #1 chk_eq("R1", vout_q, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_clear();
    set_load(330);
    pwm("R1", 3, 2.5);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_boost();
    t_hold();
    t_vin();
    t_load();
    t_clamp();
    t_div_zero();
    t_async();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule